// File: doc/BRIEF.md
# Two-Level Indirect Branch Target Predictor

This block predicts where an indirect branch will jump. It keeps two tables. A base table is indexed by the branch address alone and holds one target per branch. A second table is indexed by the branch address folded with global path history. That second table can hold several targets for the same branch, one for each history context in which the branch was seen.

A branch seen for the first time goes into the base table only. If the base table later gives a wrong target for that branch, the base entry is marked as polymorphic and the second table takes an entry keyed by the history of that prediction. Branches that always go to the same place therefore never use space in the second table.

Lookups use a valid/ready handshake. A request is accepted when `lk_valid` and `lk_ready` are both high at a clock edge. The answer appears one cycle later in a single response register. That register holds its value while `rsp_valid` is high and `rsp_ready` is low. `lk_ready` is low only while an unconsumed response is waiting. Updates come from branch resolution and cannot be refused, so the update port has no ready. The block also keeps a global history register that the caller may feed back into lookups.

Top module: `indirect_target_pred`

## Requirements
- R1: After reset, no entry in either table is valid, every lookup answers `rsp_hit`=0, and `ghist` is zero.
- R2: A base entry is selected by `ip[3:0]` and tagged with `ip[11:4]`. When an update misses the base table, the entry is written with the resolved target and its polymorphic flag is cleared. The second table is left unchanged.
- R3: A lookup that hits a base entry whose polymorphic flag is clear returns the base target with `rsp_hit`=1, whatever the history.
- R4: An update with `up_mispred`=1 that hits a base entry with a different stored target sets that entry's polymorphic flag. The base target is kept unchanged.
- R5: A second-table set is selected by `ip[2:0] ^ hist[2:0]`, and its partial tag is `ip[8:3] ^ hist[7:2]`. On an update with `up_mispred`=1 that hits the base table, a second-table hit has its target overwritten with the resolved target. On a second-table miss, an entry is allocated only if the resolved target differs from the base target.
- R6: A lookup returns the second-table target only when the base entry hits, its polymorphic flag is set, and the second table hits. If the base entry hits in any other case, the lookup returns the base target. On a base miss it returns `rsp_hit`=0 with target zero.
- R7: Within one second-table set, allocations take the 2 ways in round-robin order. A third allocation to a set evicts the oldest entry.
- R8: An update with `up_mispred`=0 that hits the base table changes neither table.
- R9: Every accepted update shifts `ghist` left by two bits and inserts `up_target[1:0]` at the bottom. With no update, `ghist` holds its value.
- R10: A lookup accepted at an edge produces `rsp_valid`=1 after that edge. The response stays stable while it is not consumed. `lk_ready` equals `!rsp_valid || rsp_ready`.
- R11: A lookup and an update in the same cycle: the lookup sees the table contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_ip | input | 32 | Branch address to predict |
| lk_hist | input | 8 | Global history used for this prediction |
| rsp_valid | output | 1 | Prediction response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Prediction target is meaningful |
| rsp_target | output | 32 | Predicted target |
| up_valid | input | 1 | Resolved branch update |
| up_ip | input | 32 | Address of the resolved branch |
| up_target | input | 32 | Actual target |
| up_hist | input | 8 | History that was used when the branch was predicted |
| up_mispred | input | 1 | The earlier prediction was wrong |
| ghist | output | 8 | Global path history register |

## Verification
The bench trains a single-target branch and then sends updates with `up_mispred`=0 and a new target. A design that lets such updates touch the tables would start returning the new target. It then fills one set of the second table with three history contexts of one branch. A wrong round-robin pointer would evict the wrong context, and an allocation that does not check the flag would answer from the second table when it should not. Same-cycle lookup and update shows whether the lookup wrongly forwards the write. A stalled response with a queued request shows whether the design drops or overwrites a response. A randomized mix of single- and multi-target branches is compared against a table model built from the requirements.

// File: rtl/itp_pkg.sv
package itp_pkg;
  localparam int DEF_IP_W       = 32;
  localparam int DEF_HIST_W     = 8;
  localparam int DEF_BASE_IDX_W = 4;
  localparam int DEF_BASE_TAG_W = 8;
  localparam int DEF_IND_SET_W  = 3;
  localparam int DEF_IND_WAYS   = 2;
  localparam int DEF_IND_TAG_W  = 6;
  localparam int DEF_SHIFT_W    = 2;
endpackage

// File: rtl/itp_hist.sv
module itp_hist #(
  parameter int HIST_W  = 8,
  parameter int SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic [SHIFT_W-1:0] shift_in,
  output logic [HIST_W-1:0]  hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-SHIFT_W-1:0], shift_in};
  end
endmodule

// File: rtl/itp_base_tbl.sv
module itp_base_tbl #(
  parameter int IP_W  = 32,
  parameter int IDX_W = 4,
  parameter int TAG_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IP_W-1:0] lk_ip,
  output logic            lk_hit,
  output logic [IP_W-1:0] lk_tgt,
  output logic            lk_poly,
  input  logic            up_valid,
  input  logic            up_mispred,
  input  logic [IP_W-1:0] up_ip,
  input  logic [IP_W-1:0] up_target,
  output logic            up_hit,
  output logic [IP_W-1:0] up_tgt
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q, poly_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [IP_W-1:0]  tgt_q [DEPTH];

  logic [IDX_W-1:0] lk_idx, up_idx;
  logic [TAG_W-1:0] lk_tag, up_tag;

  assign lk_idx  = lk_ip[IDX_W-1:0];
  assign lk_tag  = lk_ip[IDX_W +: TAG_W];
  assign up_idx  = up_ip[IDX_W-1:0];
  assign up_tag  = up_ip[IDX_W +: TAG_W];

  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_tgt  = tgt_q[lk_idx];
  assign lk_poly = poly_q[lk_idx];
  assign up_hit  = vld_q[up_idx] && (tag_q[up_idx] == up_tag);
  assign up_tgt  = tgt_q[up_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      poly_q <= '0;
    end else if (up_valid) begin
      if (!up_hit) begin
        vld_q[up_idx]  <= 1'b1;
        poly_q[up_idx] <= 1'b0;
      end else if (up_mispred && (up_tgt != up_target)) begin
        poly_q[up_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (up_valid && !up_hit) begin
      tag_q[up_idx] <= up_tag;
      tgt_q[up_idx] <= up_target;
    end
  end
endmodule

// File: rtl/itp_ind_tbl.sv
module itp_ind_tbl #(
  parameter int IP_W   = 32,
  parameter int HIST_W = 8,
  parameter int SET_W  = 3,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IP_W-1:0]   lk_ip,
  input  logic [HIST_W-1:0] lk_hist,
  output logic              lk_hit,
  output logic [IP_W-1:0]   lk_tgt,
  input  logic [IP_W-1:0]   up_ip,
  input  logic [HIST_W-1:0] up_hist,
  input  logic [IP_W-1:0]   up_target,
  output logic              up_hit,
  input  logic              wr_en
);
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [IP_W-1:0]  tgt_q [SETS][WAYS];
  logic [WAY_W-1:0] rr_q  [SETS];

  logic [SET_W-1:0] lk_set, up_set;
  logic [TAG_W-1:0] lk_tag, up_tag;
  logic [WAY_W-1:0] up_way, wr_way;

  assign lk_set = lk_ip[SET_W-1:0] ^ lk_hist[SET_W-1:0];
  assign up_set = up_ip[SET_W-1:0] ^ up_hist[SET_W-1:0];
  assign lk_tag = lk_ip[SET_W +: TAG_W] ^ lk_hist[HIST_W-1 -: TAG_W];
  assign up_tag = up_ip[SET_W +: TAG_W] ^ up_hist[HIST_W-1 -: TAG_W];

  always_comb begin
    lk_hit = 1'b0;
    lk_tgt = '0;
    up_hit = 1'b0;
    up_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag)) begin
        lk_hit = 1'b1;
        lk_tgt = tgt_q[lk_set][w];
      end
      if (vld_q[up_set][w] && (tag_q[up_set][w] == up_tag)) begin
        up_hit = 1'b1;
        up_way = WAY_W'(w);
      end
    end
  end

  assign wr_way = up_hit ? up_way : rr_q[up_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        rr_q[s]  <= '0;
      end
    end else if (wr_en) begin
      vld_q[up_set][wr_way] <= 1'b1;
      if (!up_hit)
        rr_q[up_set] <= (rr_q[up_set] == WAY_W'(WAYS - 1)) ? '0 : rr_q[up_set] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[up_set][wr_way] <= up_tag;
      tgt_q[up_set][wr_way] <= up_target;
    end
  end
endmodule

// File: rtl/indirect_target_pred.sv
module indirect_target_pred
  import itp_pkg::*;
#(
  parameter int IP_W       = DEF_IP_W,
  parameter int HIST_W     = DEF_HIST_W,
  parameter int BASE_IDX_W = DEF_BASE_IDX_W,
  parameter int BASE_TAG_W = DEF_BASE_TAG_W,
  parameter int IND_SET_W  = DEF_IND_SET_W,
  parameter int IND_WAYS   = DEF_IND_WAYS,
  parameter int IND_TAG_W  = DEF_IND_TAG_W,
  parameter int SHIFT_W    = DEF_SHIFT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IP_W-1:0]   lk_ip,
  input  logic [HIST_W-1:0] lk_hist,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [IP_W-1:0]   rsp_target,
  input  logic              up_valid,
  input  logic [IP_W-1:0]   up_ip,
  input  logic [IP_W-1:0]   up_target,
  input  logic [HIST_W-1:0] up_hist,
  input  logic              up_mispred,
  output logic [HIST_W-1:0] ghist
);
  logic            b_lk_hit, b_lk_poly, b_up_hit;
  logic [IP_W-1:0] b_lk_tgt, b_up_tgt;
  logic            i_lk_hit, i_up_hit, i_wr;
  logic [IP_W-1:0] i_lk_tgt;
  logic [IP_W-1:0] pred_tgt;
  logic            accept;

  itp_base_tbl #(.IP_W(IP_W), .IDX_W(BASE_IDX_W), .TAG_W(BASE_TAG_W)) u_base (
    .clk(clk), .rst_n(rst_n),
    .lk_ip(lk_ip), .lk_hit(b_lk_hit), .lk_tgt(b_lk_tgt), .lk_poly(b_lk_poly),
    .up_valid(up_valid), .up_mispred(up_mispred), .up_ip(up_ip),
    .up_target(up_target), .up_hit(b_up_hit), .up_tgt(b_up_tgt)
  );

  assign i_wr = up_valid && up_mispred && b_up_hit && (i_up_hit || (up_target != b_up_tgt));

  itp_ind_tbl #(.IP_W(IP_W), .HIST_W(HIST_W), .SET_W(IND_SET_W),
                .WAYS(IND_WAYS), .TAG_W(IND_TAG_W)) u_ind (
    .clk(clk), .rst_n(rst_n),
    .lk_ip(lk_ip), .lk_hist(lk_hist), .lk_hit(i_lk_hit), .lk_tgt(i_lk_tgt),
    .up_ip(up_ip), .up_hist(up_hist), .up_target(up_target),
    .up_hit(i_up_hit), .wr_en(i_wr)
  );

  itp_hist #(.HIST_W(HIST_W), .SHIFT_W(SHIFT_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(up_valid),
    .shift_in(up_target[SHIFT_W-1:0]), .hist(ghist)
  );

  always_comb begin
    if (!b_lk_hit)                 pred_tgt = '0;
    else if (b_lk_poly && i_lk_hit) pred_tgt = i_lk_tgt;
    else                           pred_tgt = b_lk_tgt;
  end

  assign lk_ready = !rsp_valid || rsp_ready;
  assign accept   = lk_valid && lk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_target <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= b_lk_hit;
      rsp_target <= pred_tgt;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/itp_chk.sv
module itp_chk #(
  parameter int IP_W    = 32,
  parameter int HIST_W  = 8,
  parameter int SHIFT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic [IP_W-1:0]   rsp_target,
  input logic              up_valid,
  input logic [IP_W-1:0]   up_target,
  input logic [HIST_W-1:0] ghist
);
  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_target));

  // R10
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> rsp_valid);

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> lk_ready);

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_target == '0);

  // R9
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist == {$past(ghist[HIST_W-SHIFT_W-1:0]), $past(up_target[SHIFT_W-1:0])});

  // R9
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));
endmodule

bind indirect_target_pred itp_chk #(.IP_W(IP_W), .HIST_W(HIST_W), .SHIFT_W(SHIFT_W)) u_chk (.*);

// File: tb/indirect_target_pred_bench.sv
module indirect_target_pred_bench;
  localparam int IPW = 32, HW = 8, NB = 16, NS = 8, NW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, lk_ready, rsp_valid, rsp_ready = 1, rsp_hit;
  logic [IPW-1:0] lk_ip = '0, rsp_target, up_ip = '0, up_target = '0;
  logic [HW-1:0] lk_hist = '0, up_hist = '0, ghist;
  logic up_valid = 0, up_mispred = 0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  indirect_target_pred u_indirect_target_pred (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_ip(lk_ip), .lk_hist(lk_hist), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_target(rsp_target), .up_valid(up_valid), .up_ip(up_ip),
    .up_target(up_target), .up_hist(up_hist), .up_mispred(up_mispred), .ghist(ghist)
  );

  // reference model built from the requirements
  bit            mb_v [NB];
  bit            mb_p [NB];
  logic [7:0]    mb_tag [NB];
  logic [31:0]   mb_tgt [NB];
  bit            mi_v [NS][NW];
  logic [5:0]    mi_tag [NS][NW];
  logic [31:0]   mi_tgt [NS][NW];
  int            mi_rr [NS];
  logic [HW-1:0] m_hist = '0;

  function automatic int iset(logic [31:0] ip, logic [7:0] h);
    return int'(ip[2:0] ^ h[2:0]);
  endfunction
  function automatic logic [5:0] itag(logic [31:0] ip, logic [7:0] h);
    return ip[8:3] ^ h[7:2];
  endfunction

  function automatic void m_pred(input logic [31:0] ip, input logic [7:0] h,
                                 output logic hit, output logic [31:0] tgt);
    int bi = int'(ip[3:0]);
    int s = iset(ip, h);
    hit = mb_v[bi] && mb_tag[bi] == ip[11:4];
    tgt = hit ? mb_tgt[bi] : 32'd0;
    if (hit && mb_p[bi])
      for (int w = 0; w < NW; w++)
        if (mi_v[s][w] && mi_tag[s][w] == itag(ip, h)) tgt = mi_tgt[s][w];
  endfunction

  function automatic void m_upd(logic [31:0] ip, logic [31:0] t, logic [7:0] h, logic mis);
    int bi = int'(ip[3:0]);
    int s = iset(ip, h);
    int hw = -1;
    logic [31:0] bt;
    if (!(mb_v[bi] && mb_tag[bi] == ip[11:4])) begin
      mb_v[bi] = 1; mb_p[bi] = 0; mb_tag[bi] = ip[11:4]; mb_tgt[bi] = t;
    end else if (mis) begin
      bt = mb_tgt[bi];
      if (bt != t) mb_p[bi] = 1;
      for (int w = 0; w < NW; w++)
        if (mi_v[s][w] && mi_tag[s][w] == itag(ip, h)) hw = w;
      if (hw >= 0) mi_tgt[s][hw] = t;
      else if (bt != t) begin
        mi_v[s][mi_rr[s]] = 1; mi_tag[s][mi_rr[s]] = itag(ip, h);
        mi_tgt[s][mi_rr[s]] = t; mi_rr[s] = (mi_rr[s] + 1) % NW;
      end
    end
    m_hist = {m_hist[HW-3:0], t[1:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] ip, input logic [7:0] h,
                        output logic hit, output logic [31:0] tgt);
    @(negedge clk);
    lk_valid = 1; lk_ip = ip; lk_hist = h;
    @(negedge clk);
    lk_valid = 0;
    hit = rsp_hit; tgt = rsp_target;
  endtask

  task automatic update(input logic [31:0] ip, input logic [31:0] t,
                        input logic [7:0] h, input logic mis);
    @(negedge clk);
    up_valid = 1; up_ip = ip; up_target = t; up_hist = h; up_mispred = mis;
    @(negedge clk);
    up_valid = 0;
    m_upd(ip, t, h, mis);
  endtask

  task automatic expect_pred(input string req, input logic [31:0] ip, input logic [7:0] h,
                             input logic ehit, input logic [31:0] etgt);
    logic hit;
    logic [31:0] tgt;
    lookup(ip, h, hit, tgt);
    check(req, {31'd0, hit, tgt}, {31'd0, ehit, etgt});
  endtask

  localparam logic [31:0] A = 32'h0000_1234;

  initial begin
    logic hit, mh;
    logic [31:0] tgt, mt;
    logic [31:0] bip [8];
    logic [31:0] btg [8][3];
    int bn [8];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    check("R1 ghist", {56'd0, ghist}, 64'd0);
    expect_pred("R1 miss", 32'h100, 8'h00, 1'b0, 32'd0);

    // R2, R3: first sight goes to base table only
    update(A, 32'h4000, 8'h00, 1'b1);
    expect_pred("R2 base alloc", A, 8'h00, 1'b1, 32'h4000);
    expect_pred("R3 any hist", A, 8'hC7, 1'b1, 32'h4000);

    // R8: correct-prediction update must not retrain
    update(A, 32'h5000, 8'h00, 1'b0);
    expect_pred("R8 no effect", A, 8'h00, 1'b1, 32'h4000);

    // R4, R5, R6: misprediction sets flag and allocates second-table entry
    update(A, 32'h5000, 8'h00, 1'b1);
    expect_pred("R6 indirect hit", A, 8'h00, 1'b1, 32'h5000);
    expect_pred("R4 base kept", A, 8'h55, 1'b1, 32'h4000);

    // R7: three contexts in one set of two ways
    update(A, 32'h6000, 8'h08, 1'b1);
    update(A, 32'h7000, 8'h10, 1'b1);
    expect_pred("R7 oldest evicted", A, 8'h00, 1'b1, 32'h4000);
    expect_pred("R7 way kept", A, 8'h08, 1'b1, 32'h6000);
    expect_pred("R7 newest", A, 8'h10, 1'b1, 32'h7000);

    // R5: overwrite on second-table hit
    update(A, 32'h7100, 8'h10, 1'b1);
    expect_pred("R5 overwrite", A, 8'h10, 1'b1, 32'h7100);

    // R11: same-cycle lookup and update
    @(negedge clk);
    lk_valid = 1; lk_ip = A; lk_hist = 8'h10;
    up_valid = 1; up_ip = A; up_target = 32'h7200; up_hist = 8'h10; up_mispred = 1;
    @(negedge clk);
    lk_valid = 0; up_valid = 0;
    m_upd(A, 32'h7200, 8'h10, 1'b1);
    check("R11 old state", {31'd0, rsp_hit, rsp_target}, {31'd0, 1'b1, 32'h7100});
    expect_pred("R11 new state", A, 8'h10, 1'b1, 32'h7200);

    // R10: back-pressure
    @(negedge clk);
    rsp_ready = 0; lk_valid = 1; lk_ip = A; lk_hist = 8'h10;
    @(negedge clk);
    lk_ip = 32'h999; lk_hist = 8'h00;
    check("R10 ready low", {63'd0, lk_ready}, 64'd0);
    @(negedge clk);
    check("R10 held", {30'd0, rsp_valid, rsp_hit, rsp_target}, {30'd0, 2'b11, 32'h7200});
    rsp_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    check("R10 next", {30'd0, rsp_valid, rsp_hit, rsp_target}, {30'd0, 2'b10, 32'd0});

    // random mix of single- and multi-target branches, R3 R6 R9
    for (int b = 0; b < 8; b++) begin
      bip[b] = $urandom;
      bn[b] = $urandom_range(1, 3);
      for (int k = 0; k < 3; k++) btg[b][k] = $urandom;
    end
    for (int it = 0; it < 600; it++) begin
      int b = $urandom_range(0, 7);
      logic [31:0] act = btg[b][$urandom_range(0, bn[b] - 1)];
      logic [7:0] h = m_hist;
      m_pred(bip[b], h, mh, mt);
      lookup(bip[b], h, hit, tgt);
      check("R6 random pred", {31'd0, hit, tgt}, {31'd0, mh, mt});
      update(bip[b], act, h, !hit || tgt != act);
      check("R9 history", {56'd0, ghist}, {56'd0, m_hist});
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule